// File: doc/BRIEF.md
# Parallel Mux-Scan Register Chains

This block wraps a small sequential circuit in mux-scan test access. The circuit is a bank of independent counters, one per chain. Each counter has its own clock-enable, and that enable is held in a register. Every counter bit is a scan cell: a flop whose data input passes through a 2-to-1 select. While `scan_en` is low, the cell takes its functional next-state bit. While `scan_en` is high, it takes the output of its upstream neighbour. The bits of each counter are stitched into one serial chain with its own serial input and serial output. All chains share the shift control and move together.

The chains are partitioned so that they can be loaded and unloaded in parallel. Chain `c` holds `BASE_LEN - c*LEN_STEP` bits. One load therefore takes `BASE_LEN` shift clocks, the length of the longest chain. The first bits fed to a shorter chain fall off its far end and act as padding.

Setting `test_mode` forces every registered clock-enable open, so a chain can never stall on its own contents. Each chain is split into two skew segments at its middle bit. The serial hop between the two segments passes through a latch that is open only while the clock is low, so a bit launched at a rising edge cannot race into the next segment.

The serial pins are plain level pins sampled on every rising edge. They carry no valid/ready handshake and apply no back-pressure: a shift happens on every clock in which the chain's enable is open and `scan_en` is high.

Top module: `scan_chains_top`

## Requirements
- R1: An active-low `rst_n` asynchronously clears every counter bit and every registered enable to 0, without waiting for a clock edge.
- R2: With `scan_en` = 0, an open chain captures its functional next state. With `scan_en` = 1, the same chain shifts instead. Shifting takes priority whatever `cnt_en` is.
- R3: The functional next state of chain `c` is its count plus one, modulo 2^len(c). Counter bit 0 is the least significant bit.
- R4: In a shift, `scan_in[c]` enters the most significant bit of chain `c` and every bit moves one place toward bit 0. `scan_out[c]` always shows bit 0, so data goes in and comes out least significant bit first.
- R5: Each chain's enable is registered. The value of `cnt_en[c] | test_mode` sampled at one rising edge governs the next edge. While that enable is closed, the chain holds its value, and this includes shifts.
- R6: `test_mode` = 1 opens every chain's enable from the following edge on, whatever `cnt_en` is.
- R7: The chains act independently, and chain `c` holds `BASE_LEN - c*LEN_STEP` bits. After `BASE_LEN` parallel shifts, a chain of length L holds the last L bits fed to it. The first `BASE_LEN - L` bits are discarded.
- R8: The lock-up stage between the two segments of a chain adds no delay and drops no bit. A bit fed to `scan_in[c]` shows on `scan_out[c]` after exactly len(c) shifts.
- R9: `state_o` concatenates the chains with chain 0 in the lowest bits. Chain `c` starts at the bit offset equal to the summed lengths of chains 0 to c-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; the lock-up latches are open while it is low |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Forces all registered clock-enables open |
| scan_en | input | 1 | 1 selects the shift path, 0 the functional path |
| cnt_en | input | NUM_CHAINS | Functional clock-enable, one per chain |
| scan_in | input | NUM_CHAINS | Serial input, one per chain |
| scan_out | output | NUM_CHAINS | Serial output (bit 0 of each chain) |
| state_o | output | TOTAL_BITS | All counter bits, packed as in R9 |

## Verification
Two things can land on the same edge: a shift request, and a functional clock-enable that is changing or has just closed. One case is `scan_en` rising in the very cycle that a `cnt_en`-only enable opens or closes. The other is `test_mode` dropping while a load is under way. The random phase draws `test_mode`, `scan_en`, `cnt_en` and `scan_in` on every cycle, each with a bias, so these collisions come up often. Each one is judged against a cycle model that keeps the enable one edge behind its inputs and gives shifting priority over counting.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Length of chain c: the longest chain comes first, each later one is shorter by step.
  function automatic int chain_len(input int c, input int base, input int step);
    return base - c * step;
  endfunction

  // Bit offset of chain c inside the packed state vector.
  function automatic int chain_off(input int c, input int base, input int step);
    int sum;
    sum = 0;
    for (int i = 0; i < c; i++) sum += chain_len(i, base, step);
    return sum;
  endfunction

  function automatic int total_bits(input int n, input int base, input int step);
    return chain_off(n, base, step);
  endfunction

  // Segment boundary inside a chain: bits at or above it form the upstream segment.
  function automatic int split_pos(input int len);
    return len / 2;
  endfunction

endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic se,
  input  logic d,
  input  logic si,
  output logic q
);
  logic d_sel;

  always_comb d_sel = se ? si : d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= d_sel;
  end
endmodule

// File: rtl/lockup_latch.sv
module lockup_latch (
  input  logic clk,
  input  logic d,
  output logic q
);
  // Open during the low phase, so the value launched at a rising edge is held back half a period.
  always_latch begin
    if (!clk) q <= d;
  end
endmodule

// File: rtl/gate_enable_reg.sv
module gate_enable_reg #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           force_open,
  input  logic [NUM-1:0] func_en,
  output logic [NUM-1:0] gate_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= '0;
    else        gate_q <= func_en | {NUM{force_open}};
  end
endmodule

// File: rtl/scan_segment.sv
module scan_segment #(
  parameter int LEN        = 8,
  parameter bit USE_LOCKUP = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gate_en,
  input  logic           scan_en,
  input  logic           scan_in,
  output logic [LEN-1:0] q,
  output logic           scan_out
);
  localparam int SPLIT = scan_pkg::split_pos(LEN);

  logic [LEN-1:0] func_d;
  logic [LEN-1:0] si_vec;
  logic           hop_q;

  always_comb func_d = q + 1'b1;

  generate
    if (USE_LOCKUP) begin : g_lockup
      lockup_latch u_lockup (.clk(clk), .d(q[SPLIT]), .q(hop_q));
    end else begin : g_direct
      assign hop_q = q[SPLIT];
    end

    for (genvar i = 0; i < LEN; i++) begin : g_bit
      if (i == LEN - 1) begin : g_head
        assign si_vec[i] = scan_in;
      end else if (i == SPLIT - 1) begin : g_hop
        assign si_vec[i] = hop_q;
      end else begin : g_link
        assign si_vec[i] = q[i+1];
      end

      scan_cell u_cell (
        .clk(clk), .rst_n(rst_n), .en(gate_en), .se(scan_en),
        .d(func_d[i]), .si(si_vec[i]), .q(q[i])
      );
    end
  endgenerate

  assign scan_out = q[0];
endmodule

// File: rtl/scan_chains_top.sv
module scan_chains_top #(
  parameter int NUM_CHAINS = 3,
  parameter int BASE_LEN   = 8,
  parameter int LEN_STEP   = 2,
  parameter bit USE_LOCKUP = 1'b1,
  localparam int TOTAL_BITS = scan_pkg::total_bits(NUM_CHAINS, BASE_LEN, LEN_STEP)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  test_mode,
  input  logic                  scan_en,
  input  logic [NUM_CHAINS-1:0] cnt_en,
  input  logic [NUM_CHAINS-1:0] scan_in,
  output logic [NUM_CHAINS-1:0] scan_out,
  output logic [TOTAL_BITS-1:0] state_o
);
  logic [NUM_CHAINS-1:0] gate_q;

  gate_enable_reg #(.NUM(NUM_CHAINS)) u_gate (
    .clk(clk), .rst_n(rst_n), .force_open(test_mode),
    .func_en(cnt_en), .gate_q(gate_q)
  );

  generate
    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
      localparam int LEN = scan_pkg::chain_len(c, BASE_LEN, LEN_STEP);
      localparam int OFF = scan_pkg::chain_off(c, BASE_LEN, LEN_STEP);
      logic [LEN-1:0] seg_q;

      scan_segment #(.LEN(LEN), .USE_LOCKUP(USE_LOCKUP)) u_seg (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_q[c]), .scan_en(scan_en),
        .scan_in(scan_in[c]), .q(seg_q), .scan_out(scan_out[c])
      );

      assign state_o[OFF +: LEN] = seg_q;
    end
  endgenerate
endmodule

// File: rtl/scan_chains_chk.sv
module scan_chains_chk #(
  parameter int NUM_CHAINS = 3,
  parameter int BASE_LEN   = 8,
  parameter int LEN_STEP   = 2,
  parameter int TOTAL_BITS = 18
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  test_mode,
  input logic                  scan_en,
  input logic [NUM_CHAINS-1:0] scan_in,
  input logic [NUM_CHAINS-1:0] gate_q,
  input logic [TOTAL_BITS-1:0] state_o
);
  // R6
  force_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> (gate_q == {NUM_CHAINS{1'b1}}));

  generate
    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_c
      localparam int L = scan_pkg::chain_len(c, BASE_LEN, LEN_STEP);
      localparam int O = scan_pkg::chain_off(c, BASE_LEN, LEN_STEP);

      // R4
      serial_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q[c] && scan_en) |=> (state_o[O+L-1] == $past(scan_in[c])));

      // R8
      shift_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q[c] && scan_en) |=> (state_o[O+L-2:O] == $past(state_o[O+L-1:O+1])));

      // R3
      capture_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q[c] && !scan_en) |=> (state_o[O +: L] == L'($past(state_o[O +: L]) + 1'b1)));

      // R5
      closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q[c] |=> $stable(state_o[O +: L]));
    end
  endgenerate
endmodule

bind scan_chains_top scan_chains_chk #(
  .NUM_CHAINS(NUM_CHAINS), .BASE_LEN(BASE_LEN), .LEN_STEP(LEN_STEP), .TOTAL_BITS(TOTAL_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_en(scan_en),
  .scan_in(scan_in), .gate_q(gate_q), .state_o(state_o)
);

// File: tb/test_scan_chains_top.sv
module test_scan_chains_top;
  localparam int NC    = 3;
  localparam int BASE  = 8;
  localparam int STEP  = 2;
  localparam int TOTAL = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tm = 1'b0;
  logic          se = 1'b0;
  logic [NC-1:0] en = '0;
  logic [NC-1:0] si = '0;
  logic [NC-1:0] so;
  logic [TOTAL-1:0] st;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [BASE-1:0] mdl [NC];
  logic [NC-1:0]   gate_m;

  always #10 clk = ~clk;

  scan_chains_top i_scan_chains_top (
    .clk(clk), .rst_n(rst_n), .test_mode(tm), .scan_en(se),
    .cnt_en(en), .scan_in(si), .scan_out(so), .state_o(st)
  );

  function automatic int lenf(input int c);
    return BASE - c * STEP;
  endfunction

  function automatic int offf(input int c);
    int s;
    s = 0;
    for (int i = 0; i < c; i++) s += lenf(i);
    return s;
  endfunction

  function automatic logic [BASE-1:0] maskf(input int c);
    return (BASE'(1) << lenf(c)) - 1'b1;
  endfunction

  function automatic logic [BASE-1:0] slice(input int c);
    logic [BASE-1:0] g;
    g = '0;
    for (int b = 0; b < lenf(c); b++) g[b] = st[offf(c) + b];
    return g;
  endfunction

  task automatic cmp(input string tag, input int c, input logic [BASE-1:0] got, input logic [BASE-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s chain %0d: got %h expected %h", tag, c, got, exp);
    end
  endtask

  // Compare packed state (R9 layout) and serial outputs against the model.
  task automatic check_all(input string tag);
    for (int c = 0; c < NC; c++) begin
      cmp(tag, c, slice(c), mdl[c]);
      cmp({tag, " R4 scan_out"}, c, BASE'(so[c]), BASE'(mdl[c][0]));
    end
  endtask

  task automatic reset_model();
    for (int c = 0; c < NC; c++) mdl[c] = '0;
    gate_m = '0;
  endtask

  // Drive at the falling edge, update the model at the rising edge, check at the next falling edge.
  task automatic cycle(input bit t, input bit s, input logic [NC-1:0] e,
                       input logic [NC-1:0] i, input string tag);
    tm = t; se = s; en = e; si = i;
    @(posedge clk);
    for (int c = 0; c < NC; c++) begin
      if (gate_m[c]) begin
        if (s) mdl[c] = (mdl[c] >> 1) | (BASE'(i[c]) << (lenf(c) - 1));
        else   mdl[c] = (mdl[c] + 1'b1) & maskf(c);
      end
    end
    gate_m = e | {NC{t}};
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog (all requirements): run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [BASE-1:0] vals [NC];
    void'($urandom(32'd1234));
    reset_model();
    repeat (2) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;

    // R5: enable registered, first edge after asserting cnt_en does nothing.
    cycle(0, 0, '1, '0, "R5 first edge");
    // R3: counting
    for (int k = 0; k < 5; k++) cycle(0, 0, '1, '0, "R3 count");
    // R5: closed gate ignores shifts
    cycle(0, 1, '0, '1, "R5 close edge");
    for (int k = 0; k < 4; k++) cycle(0, 1, '0, 3'(k), "R5 closed shift");
    // R2: functional enable alone admits shifting, with priority over counting
    cycle(0, 1, 3'b101, 3'b111, "R2 open");
    for (int k = 0; k < 3; k++) cycle(0, 1, 3'b101, 3'b010, "R2 shift");

    // R6/R7/R8: directed parallel load with padding under test_mode
    cycle(1, 1, '0, '0, "R6 open");
    for (int c = 0; c < NC; c++) vals[c] = BASE'($urandom) & maskf(c);
    vals[0] = 8'hA5;
    for (int k = 0; k < BASE; k++) begin
      logic [NC-1:0] b;
      for (int c = 0; c < NC; c++) begin
        int p;
        p = k - (BASE - lenf(c));
        b[c] = (p < 0) ? 1'($urandom) : vals[c][p];
      end
      cycle(1, 1, '0, b, "R6 load");
    end
    for (int c = 0; c < NC; c++) cmp("R7 load", c, slice(c), vals[c]);

    // R3/R2: capture with wrap from all ones
    for (int k = 0; k < BASE; k++) cycle(1, 1, '0, '1, "R8 fill ones");
    for (int c = 0; c < NC; c++) cmp("R8 ones", c, slice(c), maskf(c));
    cycle(1, 0, '0, '0, "R3 wrap capture");
    for (int c = 0; c < NC; c++) cmp("R3 wrap", c, slice(c), '0);

    // R8: alternating integrity pattern, serial out lags by chain length
    for (int k = 0; k < 2 * BASE; k++) cycle(1, 1, '0, {NC{k[0]}}, "R8 integrity");

    // R1: asynchronous reset mid-cycle
    @(negedge clk); #3 rst_n = 1'b0; #1;
    for (int c = 0; c < NC; c++) cmp("R1 async", c, slice(c), '0);
    reset_model();
    @(negedge clk); rst_n = 1'b1;
    check_all("R1 release");

    // Random mix: R2 R5 R6 collisions
    for (int k = 0; k < 1500; k++) begin
      bit t, s;
      t = ($urandom % 4) == 0;
      s = ($urandom % 2) == 0;
      cycle(t, s, NC'($urandom), NC'($urandom), "R2 R5 R6 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule